// File: doc/BRIEF.md
# Link Status and Interrupt Register File

This block is the processor-facing register bank of a sixteen-port serial switch. A host reaches it over a shared byte-wide bus that carries a six-bit address, a chip select that is active low and a direction strobe. The bank keeps one sticky error flag and one "link up" flag for each link. It also holds a per-link output-enable mask, a per-link interrupt-enable mask and a small control byte for loopback and automatic resynchronisation. The bus is shared with other devices, so the read data leaves the block as a value together with a drive-enable. A pad ring outside the block turns the pair into a tri-state pin.

The link engines talk to the block through two pulse vectors, one bit per link. A pulse on the error vector marks that link as failed. A pulse on the sync-done vector marks it as initialised again. An active-low interrupt summarises the errors of the links that are both output-enabled and interrupt-enabled. It releases by itself once every such link has resynchronised. Two board-level override inputs take priority over the control byte: one forces loopback of every port and one forces resynchronisation of every failed link.

Top module: `link_status_regs`

## Requirements
- R1: After a synchronous active-low reset, every flag, mask and control bit is 0. `int_n` is 1, `rdata_oe` is 0, `loopback_en` is 0 and `resync_req` is 0.
- R2: `rdata_oe` is 1 exactly while `cs_n` is 0 and `rd_wr` is 1. During that time `rdata` shows the addressed byte combinationally. At all other times `rdata_oe` is 0.
- R3: A register is written on a clock edge only when `cs_n` is 0 and `rd_wr` is 0. A write while `cs_n` is 1 changes nothing.
- R4: Each 16-bit per-link vector holds links 0-7 at its even address and links 8-15 at the next address, with link n at bit n mod 8. The map is: error flags 0x00/0x01, output-enable 0x02/0x03, interrupt-enable 0x04/0x05, link-up flags 0x08/0x09. The output-enable and interrupt-enable vectors are read/write.
- R5: An error pulse on a link sets that link's error flag on the next edge. The flag stays set for any number of cycles until it is cleared.
- R6: Writing the error address with a 1 in a bit clears that flag. A 0 bit leaves the flag as it is. An error pulse in the same cycle as the clearing write wins, and the flag stays set.
- R7: A sync-done pulse clears the link's error flag and sets its link-up flag. An error pulse clears the link-up flag. When both pulses arrive in the same cycle, the error wins: the error flag is set and the link-up flag is cleared.
- R8: `int_n` is 0 in the cycle after an edge that leaves any link with its error flag, output-enable bit and interrupt-enable bit all set. Otherwise it is 1.
- R9: `resync_req[n]` is 1 when link n's error flag is set and either `ext_resync` is 1 or control bit 1 (0x06) is 1.
- R10: `loopback_en` is 1 when `ext_loopback` is 1 or control bit 0 (0x06) is 1. Control bits 7:2 do not exist and read as 0.
- R11: Addresses outside the map, 0x07 and 0x0A-0x3F included, read 0x00 and ignore writes. Writes to the link-up addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Register address |
| wdata | input | 8 | Write data from the shared bus |
| rdata | output | 8 | Read data toward the bus |
| rdata_oe | output | 1 | Drive enable for the read data |
| link_err | input | 16 | Per-link error pulses |
| link_sync_done | input | 16 | Per-link sync-complete pulses |
| ext_resync | input | 1 | Override: resynchronise every failed link |
| ext_loopback | input | 1 | Override: loop every port back |
| int_n | output | 1 | Interrupt, active low |
| resync_req | output | 16 | Per-link resynchronisation request |
| loopback_en | output | 1 | Loopback command to the ports |

## Verification
The bench targets the cases where two sources act on one flag in the same cycle. An error pulse that meets a clearing write must leave the flag set; a design that puts the write first loses a real fault. An error that meets sync-done must leave the link down; a design that puts sync-done first reports a failed link as up. The interrupt is checked with only one of the two enable bits set, to catch a design that ORs the enables and interrupts the host for a link that is masked. Writes with chip select high, to unmapped addresses and to the read-only link-up bytes must be dropped; a decoder that ignores the select or aliases the address would change state the host never asked to change.

// File: rtl/lsr_pkg.sv
// Package: shared definitions for the link status register file.
// Assumes: per-link vectors are split into bytes, low links first.
package lsr_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 6;

    // Control byte bit positions.
    localparam int CTRL_LPBK_BIT = 0;
    localparam int CTRL_RSYN_BIT = 1;
    localparam int CTRL_W        = 2;

    typedef enum logic [2:0] {
        RG_ERR,
        RG_OE,
        RG_IE,
        RG_CTRL,
        RG_UP
    } region_e;

    // Base address of a region for a vector that spans vb bytes.
    function automatic int region_base(region_e r, int vb);
        case (r)
            RG_ERR:  return 0;
            RG_OE:   return vb;
            RG_IE:   return 2 * vb;
            RG_CTRL: return 3 * vb;
            default: return 3 * vb + 2;
        endcase
    endfunction

endpackage

// File: rtl/lsr_link_flags.sv
// Module: per-link sticky error flag and link-up flag.
// Assumes: inputs are single-cycle pulses that are already synchronous to clk.
// In every cell an error pulse has priority over sync-done and over a clearing write.
module lsr_link_flags #(
    parameter int NUM_LINKS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINKS-1:0] err_pulse,
    input  logic [NUM_LINKS-1:0] sync_done,
    input  logic [NUM_LINKS-1:0] w1c_mask,
    output logic [NUM_LINKS-1:0] err_q,
    output logic [NUM_LINKS-1:0] up_q
);

    for (genvar i = 0; i < NUM_LINKS; i++) begin : g_cell
        // Update one link's error flag and link-up flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                err_q[i] <= 1'b0;
                up_q[i]  <= 1'b0;
            end else begin
                if (err_pulse[i])
                    err_q[i] <= 1'b1;
                else if (sync_done[i] || w1c_mask[i])
                    err_q[i] <= 1'b0;

                if (err_pulse[i])
                    up_q[i] <= 1'b0;
                else if (sync_done[i])
                    up_q[i] <= 1'b1;
            end
        end

        // R5: a set flag survives while nothing clears it.
        a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (err_q[i] && !sync_done[i] && !w1c_mask[i]) |=> err_q[i]);

        // R7: sync-done without an error brings the link up with a clean flag.
        a_r7_sync_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (sync_done[i] && !err_pulse[i]) |=> (!err_q[i] && up_q[i]));

        // R6/R7: an error pulse always leaves the flag set and the link down.
        a_r7_error_wins: assert property (@(posedge clk) disable iff (!rst_n)
            err_pulse[i] |=> (err_q[i] && !up_q[i]));
    end

endmodule

// File: rtl/lsr_cfg_regs.sv
// Module: output-enable mask, interrupt-enable mask and control byte.
// Assumes: byte enables are decoded by the parent and are already qualified
// with chip select and the write direction.
module lsr_cfg_regs
    import lsr_pkg::*;
#(
    parameter int NUM_LINKS = 16,
    parameter int VB        = (NUM_LINKS + 7) / 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [VB-1:0]        we_oe,
    input  logic [VB-1:0]        we_ie,
    input  logic                 we_ctrl,
    input  logic [DATA_W-1:0]    wdata,
    output logic [NUM_LINKS-1:0] oe_q,
    output logic [NUM_LINKS-1:0] ie_q,
    output logic [CTRL_W-1:0]    ctrl_q
);

    for (genvar i = 0; i < NUM_LINKS; i++) begin : g_bit
        localparam int BYTE = i / 8;
        localparam int POS  = i % 8;

        // Load one mask bit from its byte lane of the write data.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                oe_q[i] <= 1'b0;
                ie_q[i] <= 1'b0;
            end else begin
                if (we_oe[BYTE]) oe_q[i] <= wdata[POS];
                if (we_ie[BYTE]) ie_q[i] <= wdata[POS];
            end
        end
    end

    // Load the implemented control bits; upper data bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (we_ctrl)
            ctrl_q <= wdata[CTRL_W-1:0];
    end

endmodule

// File: rtl/lsr_read_mux.sv
// Module: combinational read-back selector and bus drive enable.
// Assumes: unmapped addresses return zero; the drive enable follows rd_en.
module lsr_read_mux
    import lsr_pkg::*;
#(
    parameter int NUM_LINKS = 16,
    parameter int VB        = (NUM_LINKS + 7) / 8
) (
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_LINKS-1:0] err_q,
    input  logic [NUM_LINKS-1:0] up_q,
    input  logic [NUM_LINKS-1:0] oe_q,
    input  logic [NUM_LINKS-1:0] ie_q,
    input  logic [CTRL_W-1:0]    ctrl_q,
    output logic [DATA_W-1:0]    rdata,
    output logic                 rdata_oe
);

    localparam int PW        = VB * 8;
    localparam int ERR_BASE  = region_base(RG_ERR, VB);
    localparam int OE_BASE   = region_base(RG_OE, VB);
    localparam int IE_BASE   = region_base(RG_IE, VB);
    localparam int CTRL_ADDR = region_base(RG_CTRL, VB);
    localparam int UP_BASE   = region_base(RG_UP, VB);

    logic [PW-1:0]     err_pad, up_pad, oe_pad, ie_pad;
    logic [DATA_W-1:0] sel_byte;

    assign err_pad = PW'(err_q);
    assign up_pad  = PW'(up_q);
    assign oe_pad  = PW'(oe_q);
    assign ie_pad  = PW'(ie_q);

    // Pick the addressed byte; anything unmatched stays zero.
    always_comb begin
        sel_byte = '0;
        for (int b = 0; b < VB; b++) begin
            if (int'(addr) == ERR_BASE + b) sel_byte = err_pad[b*8 +: 8];
            if (int'(addr) == OE_BASE + b)  sel_byte = oe_pad[b*8 +: 8];
            if (int'(addr) == IE_BASE + b)  sel_byte = ie_pad[b*8 +: 8];
            if (int'(addr) == UP_BASE + b)  sel_byte = up_pad[b*8 +: 8];
        end
        if (int'(addr) == CTRL_ADDR)
            sel_byte = DATA_W'(ctrl_q);
    end

    assign rdata    = rd_en ? sel_byte : '0;
    assign rdata_oe = rd_en;

endmodule

// File: rtl/link_status_regs.sv
// Module: top of the link status register file. It decodes the shared bus,
// holds the per-link flags and masks, and builds the interrupt and the
// override outputs.
// Assumes: all inputs are synchronous to clk; the bus is sampled on each edge.
module link_status_regs
    import lsr_pkg::*;
#(
    parameter int NUM_LINKS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 rd_wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 rdata_oe,
    input  logic [NUM_LINKS-1:0] link_err,
    input  logic [NUM_LINKS-1:0] link_sync_done,
    input  logic                 ext_resync,
    input  logic                 ext_loopback,
    output logic                 int_n,
    output logic [NUM_LINKS-1:0] resync_req,
    output logic                 loopback_en
);

    localparam int VB        = (NUM_LINKS + 7) / 8;
    localparam int ERR_BASE  = region_base(RG_ERR, VB);
    localparam int OE_BASE   = region_base(RG_OE, VB);
    localparam int IE_BASE   = region_base(RG_IE, VB);
    localparam int CTRL_ADDR = region_base(RG_CTRL, VB);

    logic                 wr_en, rd_en;
    logic [VB-1:0]        we_err, we_oe, we_ie;
    logic                 we_ctrl;
    logic [NUM_LINKS-1:0] w1c_mask;
    logic [NUM_LINKS-1:0] err_q, up_q, oe_q, ie_q;
    logic [CTRL_W-1:0]    ctrl_q;

    assign wr_en = !cs_n && !rd_wr;
    assign rd_en = !cs_n && rd_wr;

    // Decode the per-byte write enables of each vector region.
    for (genvar b = 0; b < VB; b++) begin : g_dec
        assign we_err[b] = wr_en && (int'(addr) == ERR_BASE + b);
        assign we_oe[b]  = wr_en && (int'(addr) == OE_BASE + b);
        assign we_ie[b]  = wr_en && (int'(addr) == IE_BASE + b);
    end
    assign we_ctrl = wr_en && (int'(addr) == CTRL_ADDR);

    // Write-one-to-clear mask: route each data bit to its link.
    for (genvar i = 0; i < NUM_LINKS; i++) begin : g_w1c
        assign w1c_mask[i] = we_err[i / 8] && wdata[i % 8];
    end

    lsr_link_flags #(.NUM_LINKS(NUM_LINKS)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_pulse (link_err),
        .sync_done (link_sync_done),
        .w1c_mask  (w1c_mask),
        .err_q     (err_q),
        .up_q      (up_q)
    );

    lsr_cfg_regs #(.NUM_LINKS(NUM_LINKS), .VB(VB)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_oe   (we_oe),
        .we_ie   (we_ie),
        .we_ctrl (we_ctrl),
        .wdata   (wdata),
        .oe_q    (oe_q),
        .ie_q    (ie_q),
        .ctrl_q  (ctrl_q)
    );

    lsr_read_mux #(.NUM_LINKS(NUM_LINKS), .VB(VB)) u_rd (
        .rd_en    (rd_en),
        .addr     (addr),
        .err_q    (err_q),
        .up_q     (up_q),
        .oe_q     (oe_q),
        .ie_q     (ie_q),
        .ctrl_q   (ctrl_q),
        .rdata    (rdata),
        .rdata_oe (rdata_oe)
    );

    // Interrupt: only links that are both output- and interrupt-enabled count.
    assign int_n = ~|(err_q & oe_q & ie_q);

    // Overrides: a board input or the control bit, whichever is set.
    assign resync_req  = err_q & {NUM_LINKS{ext_resync | ctrl_q[CTRL_RSYN_BIT]}};
    assign loopback_en = ext_loopback | ctrl_q[CTRL_LPBK_BIT];

    // R2: the bus is never driven while the chip is deselected.
    a_r2_quiet_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !rdata_oe);

    // R3: a deselected cycle leaves every writable register unchanged.
    a_r3_no_write_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(oe_q) && $stable(ie_q) && $stable(ctrl_q)));

    // R8: an error on a fully enabled link pulls the interrupt low next cycle.
    a_r8_int_on_enabled_error: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && (|(link_err & oe_q & ie_q))) |=> !int_n);

    // R9: the board resync input requests every failed link.
    a_r9_resync_override: assert property (@(posedge clk) disable iff (!rst_n)
        ext_resync |-> (resync_req == err_q));

    // R10: the board loopback input forces loopback regardless of control.
    a_r10_loopback_override: assert property (@(posedge clk) disable iff (!rst_n)
        ext_loopback |-> loopback_en);

endmodule

// File: tb/test_link_status_regs.sv
module test_link_status_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_wr = 1'b1;
    logic [5:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rdata_oe;
    logic [15:0] link_err = '0;
    logic [15:0] link_sync_done = '0;
    logic        ext_resync = 1'b0;
    logic        ext_loopback = 1'b0;
    logic        int_n;
    logic [15:0] resync_req;
    logic        loopback_en;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    link_status_regs i_link_status_regs (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr(rd_wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .link_err(link_err),
        .link_sync_done(link_sync_done), .ext_resync(ext_resync),
        .ext_loopback(ext_loopback), .int_n(int_n), .resync_req(resync_req),
        .loopback_en(loopback_en)
    );

    // Table row: [22] write, [21:16] address, [15:8] data, [7:0] expected read.
    localparam int NV = 21;
    localparam logic [22:0] VECS [NV] = '{
        {1'b1, 6'h02, 8'hA5, 8'h00},
        {1'b1, 6'h03, 8'h3C, 8'h00},
        {1'b1, 6'h04, 8'h0F, 8'h00},
        {1'b1, 6'h05, 8'hF0, 8'h00},
        {1'b1, 6'h06, 8'h03, 8'h00},
        {1'b0, 6'h02, 8'h00, 8'hA5},
        {1'b0, 6'h03, 8'h00, 8'h3C},
        {1'b0, 6'h04, 8'h00, 8'h0F},
        {1'b0, 6'h05, 8'h00, 8'hF0},
        {1'b0, 6'h06, 8'h00, 8'h03},
        {1'b1, 6'h07, 8'hFF, 8'h00},
        {1'b0, 6'h07, 8'h00, 8'h00},
        {1'b1, 6'h08, 8'hFF, 8'h00},
        {1'b0, 6'h08, 8'h00, 8'h00},
        {1'b0, 6'h09, 8'h00, 8'h00},
        {1'b1, 6'h06, 8'hFC, 8'h00},
        {1'b0, 6'h06, 8'h00, 8'h00},
        {1'b0, 6'h3F, 8'h00, 8'h00},
        {1'b1, 6'h0A, 8'h55, 8'h00},
        {1'b0, 6'h0A, 8'h00, 8'h00},
        {1'b0, 6'h00, 8'h00, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; rd_wr = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; rd_wr = 1'b1;
    endtask

    task automatic bus_rd(input logic [5:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        cs_n = 1'b0; rd_wr = 1'b1; addr = a;
        #1;
        d = rdata; oe = rdata_oe;
        cs_n = 1'b1;
    endtask

    task automatic pulse(input logic [15:0] e, input logic [15:0] s);
        @(negedge clk);
        link_err = e; link_sync_done = s;
        @(negedge clk);
        link_err = '0; link_sync_done = '0;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
        logic [7:0] d;
        logic oe;
        bus_rd(a, d, oe);
        chk(req, {24'd0, d}, {24'd0, exp});
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        logic oe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        chk("R1 int_n", {31'd0, int_n}, 32'd1);
        chk("R1 rdata_oe", {31'd0, rdata_oe}, 32'd0);
        chk("R1 loopback_en", {31'd0, loopback_en}, 32'd0);
        chk("R1 resync_req", {16'd0, resync_req}, 32'd0);
        rd_chk("R1 err lo", 6'h00, 8'h00);
        rd_chk("R1 oe hi", 6'h03, 8'h00);

        // R4/R11: table walk over the map.
        for (int k = 0; k < NV; k++) begin
            if (VECS[k][22])
                bus_wr(VECS[k][21:16], VECS[k][15:8]);
            else begin
                bus_rd(VECS[k][21:16], d, oe);
                chk($sformatf("R4/R11 row %0d", k), {24'd0, d}, {24'd0, VECS[k][7:0]});
            end
        end

        // R2: drive enable only on a selected read.
        bus_rd(6'h02, d, oe);
        chk("R2 oe on read", {31'd0, oe}, 32'd1);
        @(negedge clk);
        cs_n = 1'b1; rd_wr = 1'b1; addr = 6'h02;
        #1 chk("R2 deselected", {31'd0, rdata_oe}, 32'd0);
        cs_n = 1'b0; rd_wr = 1'b0; wdata = 8'hA5;
        #1 chk("R2 write cycle", {31'd0, rdata_oe}, 32'd0);
        @(negedge clk);
        cs_n = 1'b1; rd_wr = 1'b1;

        // R3: write while deselected is dropped.
        @(negedge clk);
        cs_n = 1'b1; rd_wr = 1'b0; addr = 6'h02; wdata = 8'h00;
        @(negedge clk);
        rd_wr = 1'b1;
        rd_chk("R3 oe lo kept", 6'h02, 8'hA5);

        // R5/R8: error with output enabled but interrupt masked.
        bus_wr(6'h02, 8'hFF); bus_wr(6'h03, 8'hFF);
        bus_wr(6'h04, 8'h00); bus_wr(6'h05, 8'h00);
        pulse(16'h0008, 16'h0000);
        chk("R8 masked by ie", {31'd0, int_n}, 32'd1);
        rd_chk("R5 err set", 6'h00, 8'h08);
        bus_wr(6'h04, 8'h08);
        chk("R8 both enables", {31'd0, int_n}, 32'd0);
        bus_wr(6'h02, 8'h00);
        chk("R8 masked by oe", {31'd0, int_n}, 32'd1);
        bus_wr(6'h02, 8'hFF);
        repeat (10) @(negedge clk);
        rd_chk("R5 still set", 6'h00, 8'h08);
        chk("R8 held low", {31'd0, int_n}, 32'd0);

        // R9: resync request from pin or control bit 1.
        chk("R9 idle", {16'd0, resync_req}, 32'd0);
        ext_resync = 1'b1;
        #1 chk("R9 pin", {16'd0, resync_req}, 32'h0008);
        ext_resync = 1'b0;
        bus_wr(6'h06, 8'h02);
        chk("R9 ctrl bit", {16'd0, resync_req}, 32'h0008);
        bus_wr(6'h06, 8'h00);

        // R7: sync-done clears error and raises link-up; interrupt releases.
        pulse(16'h0000, 16'h0008);
        rd_chk("R7 err cleared", 6'h00, 8'h00);
        rd_chk("R7 up set", 6'h08, 8'h08);
        chk("R8 released", {31'd0, int_n}, 32'd1);

        // R6: write-one-to-clear.
        pulse(16'h0201, 16'h0000);
        rd_chk("R6 err lo", 6'h00, 8'h01);
        rd_chk("R6 err hi", 6'h01, 8'h02);
        bus_wr(6'h00, 8'h00);
        rd_chk("R6 zero keeps", 6'h00, 8'h01);
        bus_wr(6'h00, 8'h01);
        rd_chk("R6 one clears", 6'h00, 8'h00);
        rd_chk("R6 other byte", 6'h01, 8'h02);
        bus_wr(6'h01, 8'h02);
        rd_chk("R6 hi cleared", 6'h01, 8'h00);

        // R6: error pulse during clearing write wins.
        @(negedge clk);
        cs_n = 1'b0; rd_wr = 1'b0; addr = 6'h00; wdata = 8'h10; link_err = 16'h0010;
        @(negedge clk);
        cs_n = 1'b1; rd_wr = 1'b1; link_err = '0;
        rd_chk("R6 error wins", 6'h00, 8'h10);
        bus_wr(6'h00, 8'h10);

        // R7: error and sync-done together leave the link down.
        pulse(16'h0000, 16'h0020);
        rd_chk("R7 up bit5", 6'h08, 8'h28);
        pulse(16'h0020, 16'h0020);
        rd_chk("R7 err wins", 6'h00, 8'h20);
        rd_chk("R7 up dropped", 6'h08, 8'h08);

        // R10: loopback from pin or control bit 0.
        chk("R10 idle", {31'd0, loopback_en}, 32'd0);
        ext_loopback = 1'b1;
        #1 chk("R10 pin", {31'd0, loopback_en}, 32'd1);
        ext_loopback = 1'b0;
        bus_wr(6'h06, 8'h01);
        chk("R10 ctrl bit", {31'd0, loopback_en}, 32'd1);
        rd_chk("R10 ctrl read", 6'h06, 8'h01);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule